// File: doc/BRIEF.md
# Control Packet Decoder with Seconds Clock

This block takes a complete host packet, presented in one cycle as a byte vector with a length, and produces a complete reply packet the same way one cycle later. The first byte selects the packet class. Control-class packets are decoded and answered here. Peripheral-bus packets are forwarded untouched on a separate output. Packets of any other class are dropped.

The control commands cover a 32-bit seconds clock counted from 1 January 1904, an autopoll switch that produces a 50 Hz tick while enabled, power-off and system-reset requests, several configuration commands that are only acknowledged, and error frames for unknown commands or bad arguments. The power-off and system-reset requests come out as one-cycle pulses, one cycle after their acknowledge reply. A prescaler parameter sets how many clock cycles make one second and one poll period.

Top module: `cmd_packet_engine`

## Requirements
- R1: While reset is asserted, and after reset until the first packet, `rspValid`, `busValid`, `powerOff`, `sysReset` and `pollTick` are low and autopoll is disabled.
- R2: A control packet sampled with `pktValid` at clock edge k gives `rspValid` high for exactly the cycle after edge k. Reply byte i is `rspData[8i+7:8i]`, and the bytes from `rspLen` upward are zero.
- R3: Commands 0x13, 0x14, 0x19 and 0x21 (byte 1 of a class-1 packet) are answered with the three-byte acknowledge {0x01, 0x00, command}.
- R4: Any command without a listed meaning, including 0x00 and 0x02, is answered with the four-byte error frame {0x02, 0x02, 0x01, command}.
- R5: Command 0x03 returns seven bytes: the acknowledge header followed by the seconds count, most significant byte first.
- R6: Command 0x09 with length of at least 6 loads bytes 2..5 (most significant first) as the seconds value and restarts the second prescaler. With a shorter length it returns {0x02, 0x05, 0x01, 0x09} and leaves the clock unchanged.
- R7: After a load at edge k, the seconds value increments at edge k+CLK_PER_SEC and every CLK_PER_SEC cycles after that. It wraps from 0xFFFFFFFF to 0.
- R8: After reset the seconds value is INIT_SECONDS, which by default is 2082844800 (0x7C25B080): the count for 1 January 1970 measured from the 1904 epoch.
- R9: Command 0x01 with a nonzero byte 2 enables autopoll, and with zero disables it. Each is acknowledged. While autopoll is enabled, `pollTick` pulses once every CLK_PER_SEC/50 cycles. While it is disabled, `pollTick` never pulses. A 0x01 packet shorter than 3 bytes returns {0x02, 0x05, 0x01, 0x01}.
- R10: Command 0x0A is acknowledged, and `powerOff` then pulses for one cycle, one cycle after `rspValid`. Command 0x11 does the same with `sysReset`.
- R11: Command 0x25 always returns {0x02, 0x05, 0x01, 0x25}.
- R12: A class-0 packet appears on `busValid`/`busLen`/`busData`, unchanged and one cycle later, with no reply. Packets of classes 2 and above, and class-1 packets shorter than 2 bytes, produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pktValid | input | 1 | Packet present this cycle |
| pktLen | input | LEN_W | Packet length in bytes |
| pktData | input | 8*MAX_BYTES | Packet bytes, byte 0 in the low bits |
| rspValid | output | 1 | Reply present this cycle |
| rspLen | output | LEN_W | Reply length in bytes |
| rspData | output | 8*MAX_BYTES | Reply bytes, zero padded |
| busValid | output | 1 | Forwarded peripheral-bus packet present |
| busLen | output | LEN_W | Forwarded packet length |
| busData | output | 8*MAX_BYTES | Forwarded packet bytes |
| powerOff | output | 1 | One-cycle power-off request |
| sysReset | output | 1 | One-cycle system-reset request |
| pollTick | output | 1 | Autopoll tick |

## Verification
Replies and forwarded packets are registered once, so both are due in the cycle after the edge that samples `pktValid`. The power-off and reset pulses come one cycle after that. The bench drives each packet on a falling edge and samples every output on falling edges. Its monitor pops one expected reply for each `rspValid` cycle it sees, so a late, early or extra reply fails the comparison. For the clock, the bench counts the edges between a load and a read, and reads at CLK_PER_SEC-1 and CLK_PER_SEC+1 edges so that the expected value changes between the two reads. The poll tick is counted over a window of exactly four poll periods.

// File: rtl/cmd_packet_pkg.sv
package cmd_packet_pkg;
  localparam logic [7:0] CLS_BUS   = 8'h00;
  localparam logic [7:0] CLS_CTRL  = 8'h01;
  localparam logic [7:0] CLS_ERROR = 8'h02;

  localparam logic [7:0] WHY_UNKNOWN = 8'h02;
  localparam logic [7:0] WHY_BADARG  = 8'h05;

  localparam logic [7:0] OP_AUTOPOLL = 8'h01;
  localparam logic [7:0] OP_GETTIME  = 8'h03;
  localparam logic [7:0] OP_SETTIME  = 8'h09;
  localparam logic [7:0] OP_POWEROFF = 8'h0A;
  localparam logic [7:0] OP_RESET    = 8'h11;
  localparam logic [7:0] OP_FSFLAG   = 8'h13;
  localparam logic [7:0] OP_AUTORATE = 8'h14;
  localparam logic [7:0] OP_DEVLIST  = 8'h19;
  localparam logic [7:0] OP_PWRMSG   = 8'h21;
  localparam logic [7:0] OP_IICCOMB  = 8'h25;

  typedef struct packed {
    logic       ack;
    logic       err;
    logic [7:0] reason;
    logic       getTime;
    logic       setTime;
    logic       pollWr;
    logic       pollVal;
    logic       bypass;
    logic       powerOff;
    logic       sysReset;
  } ctlStrobe_t;
endpackage

// File: rtl/cmd_ctrl.sv
module cmd_ctrl
  import cmd_packet_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pktValid,
  input  logic [LEN_W-1:0] pktLen,
  input  logic [7:0]       cls,
  input  logic [7:0]       cmd,
  input  logic [7:0]       arg0,
  output ctlStrobe_t       stb,
  output logic             powerOff,
  output logic             sysReset
);
  logic pwrPend, rstPend;

  always_comb begin
    stb = '0;
    if (pktValid) begin
      if (cls == CLS_BUS) begin
        stb.bypass = 1'b1;
      end else if (cls == CLS_CTRL && pktLen >= LEN_W'(2)) begin
        unique case (cmd)
          OP_AUTOPOLL: begin
            if (pktLen >= LEN_W'(3)) begin
              stb.ack     = 1'b1;
              stb.pollWr  = 1'b1;
              stb.pollVal = (arg0 != 8'h00);
            end else begin
              stb.err    = 1'b1;
              stb.reason = WHY_BADARG;
            end
          end
          OP_GETTIME: begin
            stb.ack     = 1'b1;
            stb.getTime = 1'b1;
          end
          OP_SETTIME: begin
            if (pktLen >= LEN_W'(6)) begin
              stb.ack     = 1'b1;
              stb.setTime = 1'b1;
            end else begin
              stb.err    = 1'b1;
              stb.reason = WHY_BADARG;
            end
          end
          OP_POWEROFF: begin
            stb.ack      = 1'b1;
            stb.powerOff = 1'b1;
          end
          OP_RESET: begin
            stb.ack      = 1'b1;
            stb.sysReset = 1'b1;
          end
          OP_FSFLAG, OP_AUTORATE, OP_DEVLIST, OP_PWRMSG: stb.ack = 1'b1;
          OP_IICCOMB: begin
            stb.err    = 1'b1;
            stb.reason = WHY_BADARG;
          end
          default: begin
            stb.err    = 1'b1;
            stb.reason = WHY_UNKNOWN;
          end
        endcase
      end
    end
  end

  // Requests trail their acknowledge reply by one cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrPend  <= 1'b0;
      rstPend  <= 1'b0;
      powerOff <= 1'b0;
      sysReset <= 1'b0;
    end else begin
      pwrPend  <= stb.powerOff;
      rstPend  <= stb.sysReset;
      powerOff <= pwrPend;
      sysReset <= rstPend;
    end
  end

  a_r10_poweroff_after_cmd: assert property (@(posedge clk) disable iff (!rstN)
    powerOff |-> ($past(pktValid, 2) && $past(cmd, 2) == OP_POWEROFF && $past(cls, 2) == CLS_CTRL));
  a_r10_reset_after_cmd: assert property (@(posedge clk) disable iff (!rstN)
    sysReset |-> ($past(pktValid, 2) && $past(cmd, 2) == OP_RESET));
  a_r10_requests_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({powerOff, sysReset}));
endmodule

// File: rtl/cmd_datapath.sv
module cmd_datapath
  import cmd_packet_pkg::*;
#(
  parameter int          MAX_BYTES    = 8,
  parameter int          LEN_W        = 4,
  parameter int          CLK_PER_SEC  = 100_000_000,
  parameter int          POLL_HZ      = 50,
  parameter logic [31:0] INIT_SECONDS = 32'd2082844800
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobe_t             stb,
  input  logic [LEN_W-1:0]       pktLen,
  input  logic [8*MAX_BYTES-1:0] pktData,
  output logic                   rspValid,
  output logic [LEN_W-1:0]       rspLen,
  output logic [8*MAX_BYTES-1:0] rspData,
  output logic                   busValid,
  output logic [LEN_W-1:0]       busLen,
  output logic [8*MAX_BYTES-1:0] busData,
  output logic                   pollTick
);
  localparam int POLL_DIV = CLK_PER_SEC / POLL_HZ;
  localparam int SEC_W    = $clog2(CLK_PER_SEC + 1);
  localparam int POLL_W   = $clog2(POLL_DIV + 1);

  logic [31:0]            secs;
  logic [SEC_W-1:0]       secCnt;
  logic [POLL_W-1:0]      pollCnt;
  logic                   pollOn;
  logic [7:0]             cmd;
  logic [31:0]            setVal;
  logic [8*MAX_BYTES-1:0] nxtData;
  logic [LEN_W-1:0]       nxtLen;

  assign cmd    = pktData[15:8];
  assign setVal = {pktData[23:16], pktData[31:24], pktData[39:32], pktData[47:40]};

  // Seconds clock with restartable prescaler.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secs   <= INIT_SECONDS;
      secCnt <= '0;
    end else if (stb.setTime) begin
      secs   <= setVal;
      secCnt <= '0;
    end else if (secCnt == SEC_W'(CLK_PER_SEC - 1)) begin
      secs   <= secs + 32'd1;
      secCnt <= '0;
    end else begin
      secCnt <= secCnt + SEC_W'(1);
    end
  end

  // Autopoll: counter held at zero while disabled.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollOn   <= 1'b0;
      pollCnt  <= '0;
      pollTick <= 1'b0;
    end else begin
      if (stb.pollWr) pollOn <= stb.pollVal;
      pollTick <= 1'b0;
      if (!pollOn) begin
        pollCnt <= '0;
      end else if (pollCnt == POLL_W'(POLL_DIV - 1)) begin
        pollCnt  <= '0;
        pollTick <= 1'b1;
      end else begin
        pollCnt <= pollCnt + POLL_W'(1);
      end
    end
  end

  // Reply builder.
  always_comb begin
    nxtData = '0;
    nxtLen  = '0;
    if (stb.ack) begin
      nxtData[7:0]   = CLS_CTRL;
      nxtData[23:16] = cmd;
      nxtLen         = LEN_W'(3);
      if (stb.getTime) begin
        nxtData[31:24] = secs[31:24];
        nxtData[39:32] = secs[23:16];
        nxtData[47:40] = secs[15:8];
        nxtData[55:48] = secs[7:0];
        nxtLen         = LEN_W'(7);
      end
    end else if (stb.err) begin
      nxtData[31:0] = {cmd, CLS_CTRL, stb.reason, CLS_ERROR};
      nxtLen        = LEN_W'(4);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspLen   <= '0;
      rspData  <= '0;
      busValid <= 1'b0;
      busLen   <= '0;
      busData  <= '0;
    end else begin
      rspValid <= stb.ack | stb.err;
      rspLen   <= nxtLen;
      rspData  <= nxtData;
      busValid <= stb.bypass;
      if (stb.bypass) begin
        busLen  <= pktLen;
        busData <= pktData;
      end
    end
  end

  a_r7_sec_step: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(stb.setTime) && secs != $past(secs)) |-> secs == $past(secs) + 32'd1);
  a_r9_tick_needs_poll: assert property (@(posedge clk) disable iff (!rstN)
    pollTick |-> $past(pollOn));
  a_r9_tick_single: assert property (@(posedge clk) disable iff (!rstN)
    (pollTick && POLL_DIV > 1) |=> !pollTick);
endmodule

// File: rtl/cmd_packet_engine.sv
module cmd_packet_engine
  import cmd_packet_pkg::*;
#(
  parameter int          MAX_BYTES    = 8,
  parameter int          LEN_W        = $clog2(MAX_BYTES + 1),
  parameter int          CLK_PER_SEC  = 100_000_000,
  parameter logic [31:0] INIT_SECONDS = 32'd2082844800
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   pktValid,
  input  logic [LEN_W-1:0]       pktLen,
  input  logic [8*MAX_BYTES-1:0] pktData,
  output logic                   rspValid,
  output logic [LEN_W-1:0]       rspLen,
  output logic [8*MAX_BYTES-1:0] rspData,
  output logic                   busValid,
  output logic [LEN_W-1:0]       busLen,
  output logic [8*MAX_BYTES-1:0] busData,
  output logic                   powerOff,
  output logic                   sysReset,
  output logic                   pollTick
);
  ctlStrobe_t stb;

  cmd_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktLen(pktLen),
    .cls(pktData[7:0]), .cmd(pktData[15:8]), .arg0(pktData[23:16]),
    .stb(stb), .powerOff(powerOff), .sysReset(sysReset)
  );

  cmd_datapath #(
    .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .CLK_PER_SEC(CLK_PER_SEC),
    .POLL_HZ(50), .INIT_SECONDS(INIT_SECONDS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pktLen(pktLen), .pktData(pktData),
    .rspValid(rspValid), .rspLen(rspLen), .rspData(rspData),
    .busValid(busValid), .busLen(busLen), .busData(busData),
    .pollTick(pollTick)
  );

  a_r2_rsp_follows_pkt: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(pktValid) && $past(pktData[7:0]) == CLS_CTRL);
  a_r12_bus_only_class0: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> ($past(pktData[7:0]) == CLS_BUS && !rspValid));
endmodule

// File: tb/cmd_packet_engine_tb.sv
module cmd_packet_engine_tb;
  localparam int MB  = 8;
  localparam int LW  = 4;
  localparam int CPS = 200;
  localparam int PD  = CPS / 50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pktValid = 1'b0;
  logic [LW-1:0] pktLen = '0;
  logic [8*MB-1:0] pktData = '0;
  logic rspValid, busValid, powerOff, sysReset, pollTick;
  logic [LW-1:0] rspLen, busLen;
  logic [8*MB-1:0] rspData, busData;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int              len;
    logic [8*MB-1:0] data;
    string           req;
  } expItem_t;
  expItem_t sbq[$];

  always #2.5 clk = ~clk;

  cmd_packet_engine #(.MAX_BYTES(MB), .CLK_PER_SEC(CPS)) u_dut (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktLen(pktLen), .pktData(pktData),
    .rspValid(rspValid), .rspLen(rspLen), .rspData(rspData),
    .busValid(busValid), .busLen(busLen), .busData(busData),
    .powerOff(powerOff), .sysReset(sysReset), .pollTick(pollTick)
  );

  function automatic logic [8*MB-1:0] pk(input logic [7:0] b0, b1, b2 = 0, b3 = 0,
                                         b4 = 0, b5 = 0, b6 = 0);
    return {8'h00, b6, b5, b4, b3, b2, b1, b0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expectRsp(input int len, input logic [8*MB-1:0] d, input string req);
    expItem_t it;
    it.len = len; it.data = d; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic send(input int len, input logic [8*MB-1:0] d);
    @(negedge clk);
    pktValid = 1'b1; pktLen = LW'(len); pktData = d;
    @(negedge clk);
    pktValid = 1'b0; pktData = '0; pktLen = '0;
  endtask

  // Monitor: one expected item per reply cycle.
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R2 unexpected reply", rspData, 0);
      end else begin
        expItem_t it;
        it = sbq.pop_front();
        chk(rspLen == LW'(it.len), it.req, 64'(rspLen), 64'(it.len));
        chk(rspData == it.data, it.req, rspData, it.data);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ticks;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk({rspValid, busValid, powerOff, sysReset, pollTick} == 5'b0, "R1 reset outputs",
        64'({rspValid, busValid, powerOff, sysReset, pollTick}), 0);
    rstN = 1'b1;

    // R8: reset value
    expectRsp(7, pk(8'h01, 8'h00, 8'h03, 8'h7C, 8'h25, 8'hB0, 8'h80), "R8 init seconds");
    send(2, pk(8'h01, 8'h03));
    chk(pollTick == 1'b0, "R1 autopoll off after reset", 64'(pollTick), 0);

    // R3: acknowledge-only commands
    expectRsp(3, pk(8'h01, 8'h00, 8'h13), "R3 ack 0x13"); send(2, pk(8'h01, 8'h13));
    expectRsp(3, pk(8'h01, 8'h00, 8'h14), "R3 ack 0x14"); send(3, pk(8'h01, 8'h14, 8'h07));
    expectRsp(3, pk(8'h01, 8'h00, 8'h19), "R3 ack 0x19"); send(2, pk(8'h01, 8'h19));
    expectRsp(3, pk(8'h01, 8'h00, 8'h21), "R3 ack 0x21"); send(2, pk(8'h01, 8'h21));

    // R4: unknown commands; R11: 0x25
    expectRsp(4, pk(8'h02, 8'h02, 8'h01, 8'h00), "R4 unknown 0x00"); send(2, pk(8'h01, 8'h00));
    expectRsp(4, pk(8'h02, 8'h02, 8'h01, 8'h7E), "R4 unknown 0x7E"); send(2, pk(8'h01, 8'h7E));
    expectRsp(4, pk(8'h02, 8'h05, 8'h01, 8'h25), "R11 0x25 error"); send(4, pk(8'h01, 8'h25, 8'h1, 8'h2));

    // R5/R6: set then immediate get, bad set does not disturb
    expectRsp(3, pk(8'h01, 8'h00, 8'h09), "R6 set ack");
    send(6, pk(8'h01, 8'h09, 8'h12, 8'h34, 8'h56, 8'h78));
    expectRsp(4, pk(8'h02, 8'h05, 8'h01, 8'h09), "R6 short set error");
    send(5, pk(8'h01, 8'h09, 8'hAA, 8'hBB, 8'hCC));
    expectRsp(7, pk(8'h01, 8'h00, 8'h03, 8'h12, 8'h34, 8'h56, 8'h78), "R5 get big-endian");
    send(2, pk(8'h01, 8'h03));

    // R7: increment boundary
    expectRsp(3, pk(8'h01, 8'h00, 8'h09), "R7 set ack");
    send(6, pk(8'h01, 8'h09, 8'h00, 8'h00, 8'h10, 8'h00));
    repeat (CPS - 3) @(negedge clk);
    expectRsp(7, pk(8'h01, 8'h00, 8'h03, 8'h00, 8'h00, 8'h10, 8'h00), "R7 before second");
    send(2, pk(8'h01, 8'h03));
    expectRsp(3, pk(8'h01, 8'h00, 8'h09), "R7 set ack");
    send(6, pk(8'h01, 8'h09, 8'h00, 8'h00, 8'h10, 8'h00));
    repeat (CPS - 1) @(negedge clk);
    expectRsp(7, pk(8'h01, 8'h00, 8'h03, 8'h00, 8'h00, 8'h10, 8'h01), "R7 after second");
    send(2, pk(8'h01, 8'h03));
    expectRsp(3, pk(8'h01, 8'h00, 8'h09), "R7 set ack");
    send(6, pk(8'h01, 8'h09, 8'hFF, 8'hFF, 8'hFF, 8'hFF));
    repeat (CPS - 1) @(negedge clk);
    expectRsp(7, pk(8'h01, 8'h00, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00), "R7 wrap");
    send(2, pk(8'h01, 8'h03));

    // R9: autopoll
    expectRsp(4, pk(8'h02, 8'h05, 8'h01, 8'h01), "R9 short autopoll");
    send(2, pk(8'h01, 8'h01));
    repeat (2 * PD) @(negedge clk);
    ticks = 0;
    for (int i = 0; i < 4 * PD; i++) begin @(negedge clk); if (pollTick) ticks++; end
    chk(ticks == 0, "R9 no tick after bad autopoll", 64'(ticks), 0);
    expectRsp(3, pk(8'h01, 8'h00, 8'h01), "R9 enable ack");
    send(3, pk(8'h01, 8'h01, 8'h80));
    ticks = 0;
    for (int i = 0; i < 4 * PD; i++) begin @(negedge clk); if (pollTick) ticks++; end
    chk(ticks == 4, "R9 tick rate", 64'(ticks), 4);
    expectRsp(3, pk(8'h01, 8'h00, 8'h01), "R9 disable ack");
    send(3, pk(8'h01, 8'h01, 8'h00));
    @(negedge clk);
    ticks = 0;
    for (int i = 0; i < 4 * PD; i++) begin @(negedge clk); if (pollTick) ticks++; end
    chk(ticks == 0, "R9 disabled no tick", 64'(ticks), 0);

    // R10: power-off and reset pulses
    expectRsp(3, pk(8'h01, 8'h00, 8'h0A), "R10 poweroff ack");
    send(2, pk(8'h01, 8'h0A));
    chk(powerOff == 1'b0, "R10 poweroff not with reply", 64'(powerOff), 0);
    @(negedge clk);
    chk(powerOff == 1'b1 && sysReset == 1'b0, "R10 poweroff pulse", 64'({powerOff, sysReset}), 2);
    @(negedge clk);
    chk(powerOff == 1'b0, "R10 poweroff one cycle", 64'(powerOff), 0);
    expectRsp(3, pk(8'h01, 8'h00, 8'h11), "R10 reset ack");
    send(2, pk(8'h01, 8'h11));
    @(negedge clk);
    chk(sysReset == 1'b1 && powerOff == 1'b0, "R10 reset pulse", 64'({powerOff, sysReset}), 1);
    @(negedge clk);
    chk(sysReset == 1'b0, "R10 reset one cycle", 64'(sysReset), 0);

    // R12: bus passthrough and dropped classes
    send(5, pk(8'h00, 8'hC3, 8'h5A, 8'h11, 8'h22));
    chk(busValid && busLen == LW'(5) && busData == pk(8'h00, 8'hC3, 8'h5A, 8'h11, 8'h22),
        "R12 bus passthrough", busData, pk(8'h00, 8'hC3, 8'h5A, 8'h11, 8'h22));
    chk(rspValid == 1'b0, "R12 no reply for bus", 64'(rspValid), 0);
    send(2, pk(8'h03, 8'h03));
    chk({rspValid, busValid} == 2'b00, "R12 class 3 dropped", 64'({rspValid, busValid}), 0);
    send(1, pk(8'h01, 8'h03));
    chk({rspValid, busValid} == 2'b00, "R12 short control dropped", 64'({rspValid, busValid}), 0);

    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R2 all replies seen", 64'(sbq.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule